// File: doc/BRIEF.md
# Pre-Trigger Ring Capture Controller

This block runs a logic-capture memory. In capture mode it stores one byte per clock into an external parallel SRAM, with one bit per input channel. The write address steps by one on every clock and wraps at the end of the memory, so the SRAM always holds the most recent history. A trigger can arrive late from a slower controller. When it does, the block latches a start address a fixed distance behind the trigger sample. This keeps the samples that came before the event. The block then finishes the record with the remaining configured samples and stops.

A single mode input moves the block into read mode. In read mode the SRAM outputs are enabled. A slow external reader then steps through the record, one strobe edge per byte, starting from the latched start address. A test input replaces the channel data with an incrementing byte, which checks the memory path. Returning to capture mode re-arms the block.

Top module: `capture_ring_ctrl`

## Requirements
- R1: During and after reset, done_o is 0, start_addr_o is 0, and the write address, read address and test pattern counter are 0.
- R2: In capture mode, while not done, every clock is a write. sram_ce_no=0, sram_we_no=0 and sram_oe_no=1, and sram_addr_o shows the write address. The write address rises by one per write modulo 2^ADDR_W.
- R3: With test_en_i=0, the written byte equals samp_i in that cycle. Bit k of the byte carries channel k.
- R4: With test_en_i=1, the written byte equals the number of writes since reset, modulo 256.
- R5: A trigger_i high in an armed capture cycle latches start_addr_o. Its value is the address written in that cycle minus PRE_CNT, modulo 2^ADDR_W. The new value is visible from the next cycle.
- R6: After a trigger, the block makes total_len_i-PRE_CNT-1 further writes and then raises done_o. The record from start_addr_o therefore holds total_len_i bytes. If total_len_i <= PRE_CNT+1, done_o rises in the cycle after the trigger.
- R7: While done in capture mode, sram_ce_no, sram_we_no and sram_oe_no are all 1 and sram_dq_io is released (Z). Further triggers have no effect, and start_addr_o stays unchanged.
- R8: With mode_read_i=1, sram_ce_no=0, sram_oe_no=0 and sram_we_no=1. The block releases sram_dq_io, and sram_addr_o shows the read address. On entry, the read address equals start_addr_o.
- R9: In read mode, each rising edge of rd_stb_i raises the read address by one modulo 2^ADDR_W, one cycle after the edge. A strobe held high gives only one step.
- R10: In read mode the capture state is frozen. No write occurs, the write address holds, triggers are ignored, and done_o keeps its value.
- R11: In the first capture cycle after read mode, the block re-arms. done_o is 0 from the next cycle, and writes resume from the held write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_read_i | input | 1 | 1 = read mode, 0 = capture mode |
| test_en_i | input | 1 | Write the incrementing pattern instead of samples |
| trig_i | input | 1 | Trigger, sampled on the clock |
| total_len_i | input | ADDR_W+1 | Total record length in samples, pre-trigger part included |
| samp_i | input | DATA_W | Channel levels, one bit per channel |
| rd_stb_i | input | 1 | Read step strobe from the slow reader |
| sram_addr_o | output | ADDR_W | SRAM address |
| sram_dq_io | inout | DATA_W | SRAM data bus |
| sram_ce_no | output | 1 | SRAM chip enable, active low |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| start_addr_o | output | ADDR_W | Latched first address of the record |
| done_o | output | 1 | Record complete |

## Verification
The assertions assume the following about the inputs:
- rd_stb_i changes slowly enough that each rising edge is seen by the clock.
- total_len_i stays at or below the memory depth.
- PRE_CNT is smaller than the depth.

The bench drives every input only on the falling clock edge. It holds each strobe high and low for several cycles, and its record lengths stay within 1 to 256 for the default 256-byte memory. The bench also places one trigger before the write address has reached PRE_CNT, so that the start address has to wrap below zero.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_POST  = 2'd1,
    ST_DONE  = 2'd2
  } cap_st_e;
endpackage

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PRE_CNT = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              rearm_i,
  input  logic              trig_i,
  input  logic [ADDR_W:0]   total_len_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              done_o
);
  localparam int LEN_W = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] PRE_A    = ADDR_W'(PRE_CNT);
  localparam logic [LEN_W-1:0]  PRE_LAST = LEN_W'(PRE_CNT + 1);

  cap_st_e          st_q;
  logic [LEN_W-1:0] rem_q;

  assign wr_en_o = cap_en_i && (st_q != ST_DONE);
  assign done_o  = (st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_ARMED;
      wr_addr_o    <= '0;
      start_addr_o <= '0;
      rem_q        <= '0;
    end else begin
      if (wr_en_o) wr_addr_o <= wr_addr_o + 1'b1;
      if (rearm_i) begin
        st_q <= ST_ARMED;
      end else if (cap_en_i) begin
        unique case (st_q)
          ST_ARMED: if (trig_i) begin
            start_addr_o <= wr_addr_o - PRE_A;
            if (total_len_i <= PRE_LAST) begin
              st_q <= ST_DONE;
            end else begin
              rem_q <= total_len_i - PRE_LAST;
              st_q  <= ST_POST;
            end
          end
          ST_POST: begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) st_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cap_rd_ptr.sv
module cap_rd_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_mode_i,
  input  logic              stb_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic stb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q     <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      stb_q <= stb_i;
      if (!rd_mode_i)             rd_addr_o <= start_addr_i;
      else if (stb_i && !stb_q)   rd_addr_o <= rd_addr_o + 1'b1;
    end
  end
endmodule

// File: rtl/cap_pat_gen.sv
module cap_pat_gen #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [DATA_W-1:0] pat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pat_o <= '0;
    else if (step_i) pat_o <= pat_o + 1'b1;
  end
endmodule

// File: rtl/capture_ring_ctrl.sv
module capture_ring_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int PRE_CNT = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_read_i,
  input  logic              test_en_i,
  input  logic              trig_i,
  input  logic [ADDR_W:0]   total_len_i,
  input  logic [DATA_W-1:0] samp_i,
  input  logic              rd_stb_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  inout  wire  [DATA_W-1:0] sram_dq_io,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              done_o
);
  logic              mode_q;
  logic              rearm;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] pat;
  logic [DATA_W-1:0] wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_read_i;
  end

  // leaving read mode re-arms the capture
  assign rearm = mode_q && !mode_read_i;

  cap_wr_ctrl #(.ADDR_W(ADDR_W), .PRE_CNT(PRE_CNT)) i_wr_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_en_i     (!mode_read_i),
    .rearm_i      (rearm),
    .trig_i       (trig_i),
    .total_len_i  (total_len_i),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .start_addr_o (start_addr_o),
    .done_o       (done_o)
  );

  cap_rd_ptr #(.ADDR_W(ADDR_W)) i_rd_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_mode_i    (mode_read_i),
    .stb_i        (rd_stb_i),
    .start_addr_i (start_addr_o),
    .rd_addr_o    (rd_addr)
  );

  cap_pat_gen #(.DATA_W(DATA_W)) i_pat_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (wr_en),
    .pat_o  (pat)
  );

  assign wdata       = test_en_i ? pat : samp_i;
  assign sram_addr_o = mode_read_i ? rd_addr : wr_addr;
  assign sram_ce_no  = !(wr_en || mode_read_i);
  assign sram_we_no  = !wr_en;
  assign sram_oe_no  = !mode_read_i;
  assign sram_dq_io  = wr_en ? wdata : {DATA_W{1'bz}};
endmodule

// File: rtl/cap_ring_chk.sv
module cap_ring_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_read_i,
  input logic              rd_stb_i,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic [ADDR_W-1:0] start_addr_o,
  input logic              done_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R2
  wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no) |-> (!sram_ce_no && sram_oe_no));

  // R2
  wr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !sram_we_no && !$past(sram_we_no))
      |-> (sram_addr_o == ADDR_W'($past(sram_addr_o) + 1'b1)));

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mode_read_i) |-> (sram_ce_no && sram_we_no && sram_oe_no));

  // R7
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(done_o)) |-> $stable(start_addr_o));

  // R8
  rd_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_read_i |-> (!sram_ce_no && !sram_oe_no && sram_we_no));

  // R9
  rd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && mode_read_i && $past(mode_read_i) && $past(rd_stb_i) && !rd_stb_i)
      |-> $stable(sram_addr_o));
endmodule

bind capture_ring_ctrl cap_ring_chk #(.ADDR_W(ADDR_W)) i_cap_ring_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_read_i  (mode_read_i),
  .rd_stb_i     (rd_stb_i),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .start_addr_o (start_addr_o),
  .done_o       (done_o)
);

// File: tb/test_capture_ring_ctrl.sv
module test_capture_ring_ctrl;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PRE = 50;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_read_i = 1'b0;
  logic          test_en_i = 1'b0;
  logic          trig_i = 1'b0;
  logic [AW:0]   total_len_i = '0;
  logic [DW-1:0] samp_i = '0;
  logic          rd_stb_i = 1'b0;
  logic [AW-1:0] sram_addr_o;
  wire  [DW-1:0] sram_dq_io;
  logic          sram_ce_no, sram_we_no, sram_oe_no;
  logic [AW-1:0] start_addr_o;
  logic          done_o;

  always #10 clk_i = ~clk_i;

  capture_ring_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PRE_CNT(PRE)) i_capture_ring_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_read_i(mode_read_i), .test_en_i(test_en_i),
    .trig_i(trig_i), .total_len_i(total_len_i), .samp_i(samp_i), .rd_stb_i(rd_stb_i),
    .sram_addr_o(sram_addr_o), .sram_dq_io(sram_dq_io), .sram_ce_no(sram_ce_no),
    .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no), .start_addr_o(start_addr_o),
    .done_o(done_o)
  );

  // SRAM model
  logic [DW-1:0] sram [DEPTH];
  assign sram_dq_io = (!sram_ce_no && !sram_oe_no) ? sram[sram_addr_o] : {DW{1'bz}};

  // reference model
  int m_st, m_wr, m_rd, m_pat, m_start, m_rem, m_mode_q, m_stb_q;
  int exp_mem [DEPTH];
  int n_total = 0, n_bad = 0;
  int reads_done = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_wr = 0; m_rd = 0; m_pat = 0; m_start = 0; m_rem = 0;
    m_mode_q = 0; m_stb_q = 0;
  endtask

  initial begin
    model_reset();
    for (int i = 0; i < DEPTH; i++) begin sram[i] = '0; exp_mem[i] = 0; end
  end

  always @(negedge clk_i) begin
    #8;
    if (!rst_ni) begin
      chk("R1 done", int'(done_o), 0);
      chk("R1 start", int'(start_addr_o), 0);
      model_reset();
    end else begin
      bit wr, rd;
      int data;
      wr = !mode_read_i && (m_st != 2);
      rd = mode_read_i;
      data = test_en_i ? (m_pat % 256) : int'(samp_i);
      chk("R7 done", int'(done_o), m_st == 2);
      chk("R5 start", int'(start_addr_o), m_start);
      chk("R2 we_n", int'(sram_we_no), !wr);
      chk("R8 oe_n", int'(sram_oe_no), !rd);
      chk("R2 ce_n", int'(sram_ce_no), !(wr || rd));
      chk(rd ? "R9 addr" : "R2 addr", int'(sram_addr_o), rd ? m_rd : m_wr);
      if (wr) begin
        chk(test_en_i ? "R4 data" : "R3 data", int'(sram_dq_io), data);
        sram[sram_addr_o] = sram_dq_io;
        exp_mem[m_wr] = data;
      end else if (rd) begin
        chk("R8 readback", int'(sram_dq_io), exp_mem[m_rd]);
        reads_done++;
      end else begin
        n_total++;
        if (sram_dq_io !== {DW{1'bz}}) begin
          n_bad++;
          $display("FAIL R7 bus: actual=%h expected=zz", sram_dq_io);
        end
      end
      // advance model
      if (rd) begin
        if (rd_stb_i && !m_stb_q) m_rd = (m_rd + 1) % DEPTH;
      end else begin
        m_rd = m_start;
      end
      if (!mode_read_i) begin
        if (wr) begin
          m_wr = (m_wr + 1) % DEPTH;
          m_pat = m_pat + 1;
        end
        if (m_mode_q) begin
          m_st = 0;
        end else if (m_st == 0 && trig_i) begin
          m_start = (m_wr - 1 - PRE + DEPTH) % DEPTH;
          if (int'(total_len_i) <= PRE + 1) m_st = 2;
          else begin m_rem = int'(total_len_i) - PRE - 1; m_st = 1; end
        end else if (m_st == 1) begin
          if (m_rem == 1) m_st = 2;
          m_rem--;
        end
      end
      m_stb_q = rd_stb_i;
      m_mode_q = mode_read_i;
    end
  end

  int k = 0;
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      trig_i = 1'b0;
      samp_i = DW'((k * 29 + 7) ^ (k >> 3));
      k++;
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk_i);
    trig_i = 1'b1;
    samp_i = DW'(k * 13);
    k++;
  endtask

  task automatic read_steps(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); rd_stb_i = 1'b1;
      @(negedge clk_i);
      @(negedge clk_i); rd_stb_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  initial begin
    run(3);
    @(negedge clk_i); rst_ni = 1'b1;
    // R4: pattern mode, trigger before write address reaches PRE (wrap of start)
    test_en_i = 1'b1; total_len_i = 9'd100;
    run(29);
    pulse_trig();
    run(70);
    // R7: triggers ignored while done
    pulse_trig(); run(3); pulse_trig(); run(3);
    // R8 R9 R10: read back, triggers frozen
    mode_read_i = 1'b1; run(3);
    pulse_trig(); run(2);
    read_steps(100);
    // R11: re-arm with live samples, run past wrap
    mode_read_i = 1'b0; test_en_i = 1'b0; total_len_i = 9'd200;
    run(300);
    pulse_trig();
    run(200);
    mode_read_i = 1'b1; run(2);
    read_steps(205);
    // R10: read entered while armed
    mode_read_i = 1'b0; run(5);
    mode_read_i = 1'b1; pulse_trig(); run(4);
    // R6: short record finishes at once
    mode_read_i = 1'b0; total_len_i = 9'd20;
    run(10);
    pulse_trig();
    run(5);
    total_len_i = 9'd51; mode_read_i = 1'b1; run(2);
    mode_read_i = 1'b0; run(4);
    pulse_trig();
    run(5);
    // R6: full-depth record
    mode_read_i = 1'b1; run(2); mode_read_i = 1'b0; total_len_i = 9'd256;
    run(60); pulse_trig(); run(220);
    mode_read_i = 1'b1; run(2); read_steps(20);
    run(3);
    if (reads_done == 0) chk("R8 reads", 0, 1);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
    end
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
    end
    $finish;
  end
endmodule